// File: doc/BRIEF.md
# Codeword and Amplitude Merger

This block is the front stage of a parallel variable-length-code encoder output path. Each clock it can accept one symbol from the code lookup table. A symbol is a codeword of 1 to 16 bits, left-aligned in a 16-bit field, plus an amplitude of 0 to 11 bits, right-aligned in an 11-bit field. The block joins the two into one 24-bit word, left-aligned. The amplitude bits follow the last codeword bit with no gap. It also registers the total bit count, which the packing stage that follows needs.

The amplitude is not placed with one 24-bit shifter. Its position is set by comparing the total bit count against 16:
- If the total is 16 or less, a 16-bit shifter puts the whole amplitude into the upper 16 bits, and the lower 8 bits are forced to zero.
- If the total is more than 16, the upper part of the amplitude goes into the upper 16 bits. The bits that overflow spill into the lower 8 bits through an 8-bit shifter.

There is no backpressure, and the result appears one cycle after the input.

Top module: `vlc_cw_amp_merge`

## Requirements
- R1: While reset is active and until the first valid input, out_valid, out_bits and out_len are all zero.
- R2: A valid input shows up on the outputs exactly one clock later, with out_valid high. Inputs on consecutive clocks give results on consecutive clocks.
- R3: The codeword is left-aligned in in_code, and bit 15 is sent first. Bits out_bits[23 : 24-len] equal in_code[15 : 16-len], where len is in_code_len.
- R4: The amplitude is right-aligned in in_amp, and bit size-1 is sent first, where size is in_amp_size. Its size bits sit directly below the codeword, starting at out_bits[23-len]. When len+size is at most 16, out_bits[7:0] is zero.
- R5: When len+size is more than 16, the amplitude bits that do not fit above bit 8 continue without a gap into out_bits[7:0], MSB first.
- R6: out_len equals len+size for each valid symbol. Legal inputs have len from 1 to 16, size from 0 to 11, and len+size at most 24.
- R7: Every out_bits position below the top out_len bits is zero, even when in_code has stray ones below its length or in_amp has stray ones above its size.
- R8: A clock with in_valid low makes out_valid, out_len and out_bits all zero on the next clock, whatever the data inputs carry.
- R9: With amplitude size 0, the output is the codeword alone and in_amp has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Symbol present this cycle |
| in_code | input | 16 | Codeword, left-aligned |
| in_code_len | input | 5 | Codeword length, 1 to 16 |
| in_amp | input | 11 | Amplitude, right-aligned |
| in_amp_size | input | 4 | Amplitude size, 0 to 11 |
| out_valid | output | 1 | Merged word valid |
| out_bits | output | 24 | Merged word, left-aligned |
| out_len | output | 5 | Total bit count of the merged word |

## Verification
The assertions take for granted that every valid input is a legal symbol: codeword length from 1 to 16, amplitude size at most 11, and a total of at most 24. One assertion checks this input assumption directly. The stimulus keeps within these limits in both ways it builds symbols:
- Directed symbols are chosen by hand inside the limits.
- Generated symbols derive the length first, then cap the size at the smaller of 11 and 24 minus the length.

Stray bits outside the fields and garbage data on idle cycles are still driven, because the block must mask them.

// File: rtl/vlc_merge_pkg.sv
package vlc_merge_pkg;
  parameter int CODE_W = 16;
  parameter int AMP_W  = 11;
  parameter int WORD_W = 24;
  parameter int LEN_W  = $clog2(WORD_W + 1);
  parameter int SIZE_W = $clog2(AMP_W + 1);
  parameter int LOW_W  = WORD_W - CODE_W;

  // keep the top n bits of a left-aligned codeword
  function automatic logic [CODE_W-1:0] code_mask(input logic [LEN_W-1:0] n);
    return ~({CODE_W{1'b1}} >> n);
  endfunction

  // keep the low n bits of a right-aligned amplitude
  function automatic logic [AMP_W-1:0] amp_mask(input logic [SIZE_W-1:0] n);
    return ~({AMP_W{1'b1}} << n);
  endfunction

  function automatic logic [LEN_W-1:0] total_len(input logic [LEN_W-1:0] n,
                                                 input logic [SIZE_W-1:0] s);
    return n + LEN_W'(s);
  endfunction
endpackage

// File: rtl/vlc_in_clean.sv
module vlc_in_clean
  import vlc_merge_pkg::*;
(
  input  logic [CODE_W-1:0] code_raw,
  input  logic [LEN_W-1:0]  code_len,
  input  logic [AMP_W-1:0]  amp_raw,
  input  logic [SIZE_W-1:0] amp_size,
  output logic [CODE_W-1:0] code_m,
  output logic [AMP_W-1:0]  amp_m,
  output logic [LEN_W-1:0]  bit_sum
);
  assign code_m  = code_raw & code_mask(code_len);
  assign amp_m   = amp_raw & amp_mask(amp_size);
  assign bit_sum = total_len(code_len, amp_size);
endmodule

// File: rtl/vlc_split_place.sv
module vlc_split_place
  import vlc_merge_pkg::*;
(
  input  logic [AMP_W-1:0]  amp_m,
  input  logic [LEN_W-1:0]  bit_sum,
  output logic [CODE_W-1:0] hi_part,
  output logic [LOW_W-1:0]  lo_part,
  output logic              spill
);
  localparam logic [LEN_W-1:0] HI_LIM = LEN_W'(CODE_W);

  logic [LEN_W-1:0]  over_amt;
  logic [LEN_W-1:0]  left_amt;
  logic [CODE_W-1:0] amp_ext;
  logic [LOW_W-1:0]  lo_shift;

  assign spill    = bit_sum > HI_LIM;
  assign over_amt = bit_sum - HI_LIM;
  assign left_amt = HI_LIM - bit_sum;
  assign amp_ext  = {{(CODE_W-AMP_W){1'b0}}, amp_m};

  // 16-bit shifter: left when the amplitude fits, right when it spills
  assign hi_part  = spill ? (amp_ext >> over_amt) : (amp_ext << left_amt);
  // 8-bit shifter: the spilled low bits, top-aligned in the low field
  assign lo_shift = LOW_W'({amp_m, {LOW_W{1'b0}}} >> over_amt);
  assign lo_part  = spill ? lo_shift : '0;
endmodule

// File: rtl/vlc_cw_amp_merge.sv
module vlc_cw_amp_merge
  import vlc_merge_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [CODE_W-1:0] in_code,
  input  logic [LEN_W-1:0]  in_code_len,
  input  logic [AMP_W-1:0]  in_amp,
  input  logic [SIZE_W-1:0] in_amp_size,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_bits,
  output logic [LEN_W-1:0]  out_len
);
  logic [CODE_W-1:0] code_m;
  logic [AMP_W-1:0]  amp_m;
  logic [LEN_W-1:0]  bit_sum;
  logic [CODE_W-1:0] hi_part;
  logic [LOW_W-1:0]  lo_part;
  logic              spill;
  logic [WORD_W-1:0] merged;

  vlc_in_clean u_clean (
    .code_raw (in_code),
    .code_len (in_code_len),
    .amp_raw  (in_amp),
    .amp_size (in_amp_size),
    .code_m   (code_m),
    .amp_m    (amp_m),
    .bit_sum  (bit_sum)
  );

  vlc_split_place u_place (
    .amp_m   (amp_m),
    .bit_sum (bit_sum),
    .hi_part (hi_part),
    .lo_part (lo_part),
    .spill   (spill)
  );

  assign merged = {code_m | hi_part, lo_part};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_bits  <= '0;
      out_len   <= '0;
    end else begin
      out_valid <= in_valid;
      out_bits  <= in_valid ? merged : '0;
      out_len   <= in_valid ? bit_sum : '0;
    end
  end

  localparam logic [LEN_W-1:0]  LIM_HI = LEN_W'(CODE_W);
  localparam logic [LEN_W-1:0]  LIM_W  = LEN_W'(WORD_W);
  localparam logic [SIZE_W-1:0] LIM_A  = SIZE_W'(AMP_W);

  AST_IN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> (in_code_len != '0 && in_code_len <= LIM_HI && in_amp_size <= LIM_A
                  && (in_code_len + LEN_W'(in_amp_size)) <= LIM_W)); // R6
  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R2
  AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && out_len == '0 && out_bits == '0)); // R8
  AST_LEN_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_len == ($past(in_code_len) + LEN_W'($past(in_amp_size)))); // R6
  AST_TAIL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_bits & ({WORD_W{1'b1}} >> out_len)) == '0); // R7
  AST_LOW_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_len <= LIM_HI) |-> out_bits[LOW_W-1:0] == '0); // R4
  AST_SPILL_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && spill) |=> out_len > LIM_HI); // R5
  AST_CODE_PREFIX: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_bits[WORD_W-1 -: CODE_W] & code_mask($past(in_code_len)))
                  == ($past(in_code) & code_mask($past(in_code_len)))); // R3
endmodule

// File: tb/vlc_cw_amp_merge_test.sv
`timescale 1ns/1ps
module vlc_cw_amp_merge_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] in_code = '0;
  logic [4:0]  in_code_len = '0;
  logic [10:0] in_amp = '0;
  logic [3:0]  in_amp_size = '0;
  logic        out_valid;
  logic [23:0] out_bits;
  logic [4:0]  out_len;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  vlc_cw_amp_merge uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_code(in_code),
    .in_code_len(in_code_len), .in_amp(in_amp), .in_amp_size(in_amp_size),
    .out_valid(out_valid), .out_bits(out_bits), .out_len(out_len)
  );

  // bit-by-bit concatenation model
  function automatic logic [23:0] model(input logic [15:0] c, input int l,
                                        input logic [10:0] a, input int s);
    logic [23:0] r;
    int p;
    r = '0;
    p = 23;
    for (int i = 0; i < l; i++) begin r[p] = c[15-i]; p--; end
    for (int j = 0; j < s; j++) begin r[p] = a[s-1-j]; p--; end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  // called at a negedge: drive symbol, check it at the next negedge
  task automatic sym(input logic [15:0] c, input int l, input logic [10:0] a,
                     input int s, input string tag);
    in_valid = 1'b1; in_code = c; in_code_len = 5'(l);
    in_amp = a; in_amp_size = 4'(s);
    @(negedge clk);
    chk("R2 out_valid", {31'b0, out_valid}, 32'd1);
    chk(tag, {8'b0, out_bits}, {8'b0, model(c, l, a, s)});
    chk("R6 out_len", {27'b0, out_len}, 32'(l + s));
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 valid", {31'b0, out_valid}, 0);
    chk("R1 bits", {8'b0, out_bits}, 0);
    chk("R1 len", {27'b0, out_len}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid after release", {31'b0, out_valid}, 0);
  endtask

  task automatic t_fit;
    sym(16'hA000, 3, 11'h005, 3, "R3 R4 short fit");
    sym(16'hC000, 2, 11'h3FF, 10, "R4 fit 12");
    sym(16'hB6D0, 12, 11'h00D, 4, "R4 fit exactly 16");
  endtask

  task automatic t_spill;
    sym(16'hFFF0, 12, 11'h155, 9, "R5 spill 21");
    sym(16'h1230, 12, 11'h7FF, 11, "R5 spill 23");
    sym(16'hFFFF, 16, 11'h0A5, 8, "R5 full 24");
    sym(16'h8000, 15, 11'h001, 2, "R5 spill by one");
  endtask

  task automatic t_mask;
    sym(16'hFFFF, 3, 11'h7FF, 2, "R7 stray bits");
    chk("R7 exact word", {8'b0, out_bits}, 32'h00F80000);
    sym(16'h5FFF, 4, 11'h7F2, 3, "R7 stray both");
  endtask

  task automatic t_size0;
    sym(16'hA800, 5, 11'h7FF, 0, "R9 size zero");
    chk("R9 code only", {8'b0, out_bits}, 32'h00A80000);
    sym(16'hFFFF, 16, 11'h123, 0, "R9 size zero full code");
  endtask

  task automatic t_idle;
    in_valid = 1'b0; in_code = 16'hFFFF; in_code_len = 5'd9;
    in_amp = 11'h7FF; in_amp_size = 4'd7;
    @(negedge clk);
    chk("R8 valid", {31'b0, out_valid}, 0);
    chk("R8 bits", {8'b0, out_bits}, 0);
    chk("R8 len", {27'b0, out_len}, 0);
    sym(16'h4000, 2, 11'h001, 1, "R2 resume after idle");
  endtask

  task automatic t_stream;
    logic [31:0] lf;
    lf = 32'h1ACE5EED;
    for (int n = 0; n < 300; n++) begin
      int l;
      int smax;
      int s;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      l = 1 + int'(lf[3:0]);
      smax = (24 - l < 11) ? 24 - l : 11;
      s = int'(lf[11:8]) % (smax + 1);
      sym(lf[31:16], l, lf[26:16], s, "R2 R3 R4 R5 stream");
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_fit();
    t_spill();
    t_mask();
    t_size0();
    t_idle();
    t_stream();
    t_idle();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule